// File: doc/BRIEF.md
# Serial Bit Clock and Frame Sync Generator

This block derives the timing for a synchronous serial port from the core clock, using clock enables only. A configurable divider chain produces a bit clock pin value and a one-cycle bit enable. A word counter divides the bit rate by the selected word length. A slot counter divides the word rate by the selected frame size. From these counts the block produces a word boundary pulse, a frame sync and the current slot index.

The divider chain has three stages. A fixed divide-by-2 comes first. A divide-by-8 range stage follows, and it is bypassed while the range control is set. The last stage is an 8-bit modulus divider with ratios from 1 to 256. The fastest bit clock is therefore the core clock divided by 4, and the slowest is the core clock divided by 4096.

A single load strobe captures every control field. The same strobe restarts all counters, so a new setting always begins at bit 0 of slot 0.

Top module: `sclk_gen`

## Requirements
- R1: After reset all control fields are zero: the bit period is 16 core cycles, words are 8 bits, there is one word per frame, `bitClkOut` and `bitTick` are low, `slotIdx` is 0 and `frameSync` is high.
- R2: One bit period lasts 2 × D × (`cfgPrescale`+1) core cycles, where D is 1 when `cfgRangeBypass` is 1 and 8 when it is 0. `bitClkOut` is low for the first half of each period and high for the second half, and each period starts low.
- R3: `bitTick` is high for exactly one core cycle per bit period: the last cycle of the period.
- R4: The forbidden setting `cfgRangeBypass`=1 with `cfgPrescale`=0 is run as if `cfgPrescale` were 1, which gives a 4-cycle bit period.
- R5: `cfgWordLen` selects the bits per word: 000→8, 001→12, 010→16, 011→24, 100 and 101→32, and the unused codes 110 and 111→32. `wordTick` equals `bitTick` on the last bit of each word and is low otherwise.
- R6: `slotIdx` counts the words of a frame from 0 to F−1, where F = `cfgFrameDiv`+1. It advances in the cycle after `wordTick` and wraps to 0.
- R7: With `cfgNetwork`=1 and `cfgFrameDiv`=0, the frame holds 2 slots.
- R8: With `cfgSyncLen`=01, `frameSync` is high during bit 0 of slot 0. With any other value it is high for all of slot 0.
- R9: With `cfgNetwork`=0 and `cfgFrameDiv`=0, the frame sync is bit-length whatever the value of `cfgSyncLen`.
- R10: When `cfgWe` is high at a clock edge, every field is loaded and all counters restart. In the next cycle `bitClkOut` is low, `bitTick` is low and `slotIdx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Load strobe for all control fields; restarts all counters |
| cfgPrescale | input | 8 | Modulus divider field N (ratio N+1) |
| cfgRangeBypass | input | 1 | 1 bypasses the divide-by-8 stage |
| cfgWordLen | input | 3 | Word length code |
| cfgFrameDiv | input | 5 | Words per frame minus one |
| cfgNetwork | input | 1 | Selects network (multi-slot) mode |
| cfgSyncLen | input | 2 | Frame sync length select (01 = one bit) |
| bitClkOut | output | 1 | Bit clock pin value |
| bitTick | output | 1 | One-cycle pulse at the end of each bit period |
| wordTick | output | 1 | One-cycle pulse at the end of each word |
| frameSync | output | 1 | Frame sync, one bit or one word long |
| slotIdx | output | 5 | Index of the current word within the frame |

## Verification
The bench builds the block with its default parameters: an 8-bit modulus field and an 8-way range stage. This brings both ends of the bit-period range within reach. The 4-cycle minimum is covered, including the forbidden setting, and so is the 4096-cycle maximum.

The bench also runs a 32-slot frame with 24-bit words. It walks every word-length code, including the unused ones. It covers both frame sync lengths, the single-word frame in normal and in network mode, and a reload in the middle of a frame.

// File: rtl/sclk_pkg.sv
package sclk_pkg;
  localparam int FRAME_W = 5;
  localparam int WORD_CNT_W = 5;
  localparam int WL_W = 3;
  localparam int FSL_W = 2;

  // Strobes from the control module to the datapath.
  typedef struct packed {
    logic restart;
    logic bitEnd;
    logic upperHalf;
  } sclkStrobe_t;

  // Frame shape decoded from the loaded control fields.
  typedef struct packed {
    logic [WORD_CNT_W-1:0] wordLast;
    logic [FRAME_W-1:0]    frameLast;
    logic                  bitSync;
  } sclkShape_t;

  function automatic logic [WORD_CNT_W-1:0] wordLastOf(input logic [WL_W-1:0] code);
    case (code)
      3'd0:    wordLastOf = WORD_CNT_W'(7);
      3'd1:    wordLastOf = WORD_CNT_W'(11);
      3'd2:    wordLastOf = WORD_CNT_W'(15);
      3'd3:    wordLastOf = WORD_CNT_W'(23);
      default: wordLastOf = WORD_CNT_W'(31);
    endcase
  endfunction
endpackage

// File: rtl/sclk_ctrl.sv
module sclk_ctrl import sclk_pkg::*; #(
  parameter int PRESCALE_W = 8,
  parameter int FIXED_DIV  = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgWe,
  input  logic [PRESCALE_W-1:0] cfgPrescale,
  input  logic                  cfgRangeBypass,
  input  logic [WL_W-1:0]       cfgWordLen,
  input  logic [FRAME_W-1:0]    cfgFrameDiv,
  input  logic                  cfgNetwork,
  input  logic [FSL_W-1:0]      cfgSyncLen,
  output sclkStrobe_t           strobe,
  output sclkShape_t            shape
);
  localparam int CNT_W = $clog2(2 * FIXED_DIV * (2 ** PRESCALE_W));

  logic [PRESCALE_W-1:0] preReg;
  logic                  bypReg;
  logic [WL_W-1:0]       wlReg;
  logic [FRAME_W-1:0]    fdReg;
  logic                  netReg;
  logic [FSL_W-1:0]      fslReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preReg <= '0;
      bypReg <= 1'b0;
      wlReg  <= '0;
      fdReg  <= '0;
      netReg <= 1'b0;
      fslReg <= '0;
    end else if (cfgWe) begin
      preReg <= cfgPrescale;
      bypReg <= cfgRangeBypass;
      wlReg  <= cfgWordLen;
      fdReg  <= cfgFrameDiv;
      netReg <= cfgNetwork;
      fslReg <= cfgSyncLen;
    end
  end

  logic [CNT_W-1:0] modPlus;
  logic [CNT_W-1:0] halfLen;
  logic [CNT_W-1:0] periodLast;
  logic [CNT_W-1:0] cycCnt;

  // Modulus stage; the forbidden fastest setting is promoted to ratio 2.
  always_comb begin
    modPlus = CNT_W'(preReg) + CNT_W'(1);
    if (bypReg && preReg == '0) modPlus = CNT_W'(2);
  end

  generate
    if (FIXED_DIV > 1) begin : g_range
      assign halfLen = bypReg ? modPlus : modPlus * CNT_W'(FIXED_DIV);
    end else begin : g_norange
      assign halfLen = modPlus;
    end
  endgenerate

  // The fixed divide-by-2 makes the full period twice the half period.
  assign periodLast = (halfLen << 1) - CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN || cfgWe)          cycCnt <= '0;
    else if (cycCnt == periodLast) cycCnt <= '0;
    else                          cycCnt <= cycCnt + CNT_W'(1);
  end

  always_comb begin
    strobe.restart   = cfgWe;
    strobe.bitEnd    = (cycCnt == periodLast);
    strobe.upperHalf = (cycCnt >= halfLen);
    shape.wordLast   = wordLastOf(wlReg);
    shape.frameLast  = (netReg && fdReg == '0) ? FRAME_W'(1) : fdReg;
    shape.bitSync    = (fslReg == FSL_W'(1)) || (!netReg && fdReg == '0);
  end
endmodule

// File: rtl/sclk_datapath.sv
module sclk_datapath import sclk_pkg::*; (
  input  logic               clk,
  input  logic               rstN,
  input  sclkStrobe_t        strobe,
  input  sclkShape_t         shape,
  output logic               bitClkOut,
  output logic               bitTick,
  output logic               wordTick,
  output logic               frameSync,
  output logic [FRAME_W-1:0] slotIdx
);
  logic [WORD_CNT_W-1:0] bitCnt;
  logic [FRAME_W-1:0]    slotCnt;
  logic                  lastBit;

  assign lastBit = (bitCnt == shape.wordLast);

  always_ff @(posedge clk) begin
    if (!rstN || strobe.restart) begin
      bitCnt  <= '0;
      slotCnt <= '0;
    end else if (strobe.bitEnd) begin
      if (lastBit) begin
        bitCnt  <= '0;
        slotCnt <= (slotCnt == shape.frameLast) ? '0 : slotCnt + FRAME_W'(1);
      end else begin
        bitCnt <= bitCnt + WORD_CNT_W'(1);
      end
    end
  end

  always_comb begin
    bitClkOut = strobe.upperHalf;
    bitTick   = strobe.bitEnd;
    wordTick  = strobe.bitEnd && lastBit;
    frameSync = (slotCnt == '0) && (!shape.bitSync || bitCnt == '0);
    slotIdx   = slotCnt;
  end
endmodule

// File: rtl/sclk_gen.sv
module sclk_gen import sclk_pkg::*; #(
  parameter int PRESCALE_W = 8,
  parameter int FIXED_DIV  = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgWe,
  input  logic [PRESCALE_W-1:0] cfgPrescale,
  input  logic                  cfgRangeBypass,
  input  logic [WL_W-1:0]       cfgWordLen,
  input  logic [FRAME_W-1:0]    cfgFrameDiv,
  input  logic                  cfgNetwork,
  input  logic [FSL_W-1:0]      cfgSyncLen,
  output logic                  bitClkOut,
  output logic                  bitTick,
  output logic                  wordTick,
  output logic                  frameSync,
  output logic [FRAME_W-1:0]    slotIdx
);
  sclkStrobe_t strobe;
  sclkShape_t  shape;

  sclk_ctrl #(.PRESCALE_W(PRESCALE_W), .FIXED_DIV(FIXED_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgPrescale(cfgPrescale),
    .cfgRangeBypass(cfgRangeBypass), .cfgWordLen(cfgWordLen),
    .cfgFrameDiv(cfgFrameDiv), .cfgNetwork(cfgNetwork),
    .cfgSyncLen(cfgSyncLen), .strobe(strobe), .shape(shape)
  );

  sclk_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .shape(shape),
    .bitClkOut(bitClkOut), .bitTick(bitTick), .wordTick(wordTick),
    .frameSync(frameSync), .slotIdx(slotIdx)
  );
endmodule

// File: rtl/sclk_checker.sv
module sclk_checker import sclk_pkg::*; (
  input logic               clk,
  input logic               rstN,
  input logic               cfgWe,
  input logic               bitClkOut,
  input logic               bitTick,
  input logic               wordTick,
  input logic               frameSync,
  input logic [FRAME_W-1:0] slotIdx
);
  AST_TICK_IN_HIGH_HALF: assert property (@(posedge clk) disable iff (!rstN)
    bitTick |-> bitClkOut); // R3
  AST_CLK_LOW_AFTER_TICK: assert property (@(posedge clk) disable iff (!rstN)
    bitTick |=> !bitClkOut); // R2
  AST_WORD_ON_BIT: assert property (@(posedge clk) disable iff (!rstN)
    wordTick |-> bitTick); // R5
  AST_SLOT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!wordTick && !cfgWe) |=> $stable(slotIdx)); // R6
  AST_SYNC_IN_SLOT0: assert property (@(posedge clk) disable iff (!rstN)
    frameSync |-> (slotIdx == '0)); // R8
  AST_RESTART_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    cfgWe |=> (!bitClkOut && !bitTick && slotIdx == '0)); // R10
endmodule

bind sclk_gen sclk_checker u_sclk_checker (
  .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .bitClkOut(bitClkOut),
  .bitTick(bitTick), .wordTick(wordTick), .frameSync(frameSync),
  .slotIdx(slotIdx)
);

// File: tb/test_sclk_gen.sv
`timescale 1ns/1ps
module test_sclk_gen;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWe = 1'b0;
  logic [7:0] cPre = '0;
  logic       cByp = 1'b0;
  logic [2:0] cWl = '0;
  logic [4:0] cFd = '0;
  logic       cNet = 1'b0;
  logic [1:0] cFsl = '0;
  logic       bitClkOut, bitTick, wordTick, frameSync;
  logic [4:0] slotIdx;

  int nChecks = 0;
  int nFail = 0;
  int cyc = 0;
  bit compareOn = 1'b0;

  // Behavioural reference state: time since restart plus the frame shape.
  int t = 0;
  int mP = 16, mW = 8, mF = 1;
  bit mBitSync = 1'b1;
  int maxSlot = 0;

  always #2.5 clk = ~clk;

  sclk_gen i_sclk_gen (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgPrescale(cPre),
    .cfgRangeBypass(cByp), .cfgWordLen(cWl), .cfgFrameDiv(cFd),
    .cfgNetwork(cNet), .cfgSyncLen(cFsl), .bitClkOut(bitClkOut),
    .bitTick(bitTick), .wordTick(wordTick), .frameSync(frameSync),
    .slotIdx(slotIdx)
  );

  task automatic chk(input int act, input int exp, input string tag);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic setModel(input int pre, input bit byp, input int wl,
                          input int fd, input bit net, input int fsl);
    int p;
    p = (byp && pre == 0) ? 1 : pre;
    mP = 2 * (p + 1) * (byp ? 1 : 8);
    case (wl)
      0: mW = 8;
      1: mW = 12;
      2: mW = 16;
      3: mW = 24;
      default: mW = 32;
    endcase
    mF = (fd == 0 && net) ? 2 : fd + 1;
    mBitSync = (fsl == 1) || (fd == 0 && !net);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rstN) begin
      t = 0;
      setModel(0, 1'b0, 0, 0, 1'b0, 0);
    end else if (cfgWe) begin
      t = 0;
      setModel(cPre, cByp, cWl, cFd, cNet, cFsl);
    end else begin
      t++;
    end
    if (cyc > 150000) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  // Per-cycle comparison against the reference, away from the active edge.
  always @(negedge clk) begin
    if (rstN && compareOn) begin
      int phase, bitIdx, bitInWord, slot;
      phase     = t % mP;
      bitIdx    = t / mP;
      bitInWord = bitIdx % mW;
      slot      = (bitIdx / mW) % mF;
      chk(int'(bitClkOut), int'(phase >= mP / 2), "R2 bitClkOut");
      chk(int'(bitTick), int'(phase == mP - 1), "R3 bitTick");
      chk(int'(wordTick), int'(phase == mP - 1 && bitInWord == mW - 1), "R5 wordTick");
      chk(int'(slotIdx), slot, "R6 slotIdx");
      chk(int'(frameSync), int'(slot == 0 && (!mBitSync || bitInWord == 0)), "R8 frameSync");
      if (int'(slotIdx) > maxSlot) maxSlot = int'(slotIdx);
    end
  end

  task automatic applyCfg(input int pre, input bit byp, input int wl,
                          input int fd, input bit net, input int fsl);
    @(posedge clk); #1;
    cPre = 8'(pre); cByp = byp; cWl = 3'(wl); cFd = 5'(fd); cNet = net; cFsl = 2'(fsl);
    cfgWe = 1'b1;
    @(posedge clk); #1;
    cfgWe = 1'b0;
    maxSlot = 0;
    chk(int'(bitClkOut), 0, "R10 bitClkOut after load");
    chk(int'(slotIdx), 0, "R10 slotIdx after load");
  endtask

  task automatic measureBit(input int exp, input string tag);
    int n;
    @(negedge clk);
    while (!bitTick) @(negedge clk);
    n = 0;
    do begin @(negedge clk); n++; end while (!bitTick);
    chk(n, exp, tag);
  endtask

  task automatic measureWord(input int exp, input string tag);
    int n;
    @(negedge clk);
    while (!wordTick) @(negedge clk);
    n = 0;
    do begin @(negedge clk); n++; end while (!wordTick);
    chk(n, exp, tag);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    // R1: reset state, sampled after the release edge.
    chk(int'(bitClkOut), 0, "R1 bitClkOut");
    chk(int'(bitTick), 0, "R1 bitTick");
    chk(int'(slotIdx), 0, "R1 slotIdx");
    chk(int'(frameSync), 1, "R1 frameSync");
    compareOn = 1'b1;
    measureBit(16, "R1 default bit period");
    measureWord(128, "R1 default word period");
    repeat (300) @(posedge clk);

    // R2: fastest legal setting, 12-bit words, 3 slots, word-length sync.
    applyCfg(1, 1'b1, 1, 2, 1'b0, 0);
    repeat (9) @(posedge clk); #1;
    chk(int'(frameSync), 1, "R8 word-length sync mid slot 0");
    repeat (39) @(posedge clk); #1;
    chk(int'(frameSync), 0, "R8 word-length sync off in slot 1");
    measureBit(4, "R2 minimum bit period");
    repeat (600) @(posedge clk);

    // R4: forbidden setting behaves as a 4-cycle period; R7: network, 2 slots.
    applyCfg(0, 1'b1, 2, 0, 1'b1, 0);
    measureBit(4, "R4 forbidden setting period");
    repeat (500) @(posedge clk);
    chk(maxSlot, 1, "R7 network single-divider slot count");

    // R9: normal mode, divider 0, sync select 00 still gives bit-length sync.
    applyCfg(0, 1'b0, 0, 0, 1'b0, 0);
    repeat (19) @(posedge clk); #1;
    chk(int'(frameSync), 0, "R9 forced bit-length sync");
    repeat (300) @(posedge clk);

    // R2: slowest setting.
    applyCfg(255, 1'b0, 0, 0, 1'b0, 1);
    measureBit(4096, "R2 maximum bit period");

    // R5: each word-length code, including the unused ones.
    applyCfg(1, 1'b1, 4, 1, 1'b0, 1);
    measureWord(128, "R5 code 100");
    applyCfg(1, 1'b1, 5, 1, 1'b0, 1);
    measureWord(128, "R5 code 101");
    applyCfg(1, 1'b1, 6, 1, 1'b0, 1);
    measureWord(128, "R5 code 110");
    applyCfg(1, 1'b1, 7, 1, 1'b0, 1);
    measureWord(128, "R5 code 111");
    applyCfg(2, 1'b1, 2, 1, 1'b0, 0);
    measureWord(96, "R5 code 010");

    // R6: 32 slots of 24-bit words with bit-length sync, reloaded mid-frame.
    applyCfg(1, 1'b1, 3, 31, 1'b1, 1);
    repeat (5000) @(posedge clk);
    chk(maxSlot, 31, "R6 top slot reached");
    applyCfg(3, 1'b0, 1, 4, 1'b1, 1);
    repeat (3000) @(posedge clk);

    @(negedge clk);
    compareOn = 1'b0;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule